// File: doc/BRIEF.md
# Doubleword Load/Store Unit

This block carries out the three memory instructions that move 64-bit and unsigned 32-bit data on a 64-bit integer core: a doubleword load, an unsigned word load that zero-fills the upper half, and a doubleword store. The core hands it the raw 32-bit instruction word together with the values of the base register and the store-source register. The unit decodes the instruction, forms the effective address, and either reports a misaligned access or issues one request on a simple synchronous memory port.

After the request is accepted, the unit waits for the memory's response-valid pulse. It then produces a one-cycle completion pulse and, for loads, a register-file write. Memory is 64 bits wide and little-endian. An unsigned word load picks one half of the returned doubleword using address bit 2. The unit takes one instruction at a time and ignores new start pulses while it is busy.

Top module: `ldst_unit`

## Requirements
- R1: An instruction is accepted only when its opcode bits [6:0] and funct3 bits [14:12] match one of three pairs: 0000011/011 (doubleword load), 0000011/110 (unsigned word load) or 0100011/011 (doubleword store). Any other word given with a start pulse causes no request, no completion and no busy indication.
- R2: The load address is the 64-bit base value plus the sign-extended 12-bit immediate taken from instruction bits [31:20].
- R3: The store address is the base plus the sign-extended immediate {instr[31:25], instr[11:7]}. The request carries write-enable high, all eight byte strobes set, and the full 64-bit store-source value as write data.
- R4: The request, with its address and write data, stays asserted and unchanged from the cycle after the start until the first cycle in which the grant input is high. It drops in the following cycle.
- R5: A doubleword load writes the whole 64-bit response word to the destination register.
- R6: An unsigned word load zero-extends one 32-bit half of the response. The upper half (bits 63:32) is used when address bit 2 is 1, and the lower half otherwise. The byte strobes are 8'hF0 for the upper half and 8'h0F for the lower half. A doubleword load uses 8'hFF.
- R7: A load whose destination field (bits [11:7]) is 0 still performs the memory access and completes, but it does not raise the register-write enable.
- R8: The done output pulses for exactly one cycle, in the cycle after the response-valid input is sampled high. Register-write enable, destination index and data are valid in that same cycle. A store completes with the write enable low.
- R9: An address that is not a multiple of 8 for a doubleword access, or not a multiple of 4 for an unsigned word load, issues no request. Instead, done and the misaligned flag are raised together in the cycle after the start, with no register write.
- R10: Busy is high from the cycle after an accepted start until the completion cycle. Start pulses while busy are ignored and do not change the request in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Issue pulse for the instruction on instr_i |
| instr_i | input | 32 | Instruction word |
| base_i | input | 64 | Base register value |
| src2_i | input | 64 | Store-source register value |
| busy_o | output | 1 | An operation is in progress |
| mem_req_o | output | 1 | Memory request valid |
| mem_gnt_i | input | 1 | Memory accepts the request this cycle |
| mem_addr_o | output | 64 | Request byte address |
| mem_we_o | output | 1 | Request is a write |
| mem_be_o | output | 8 | Byte lane strobes |
| mem_wdata_o | output | 64 | Write data |
| mem_rvalid_i | input | 1 | Response-valid pulse |
| mem_rdata_i | input | 64 | Response data |
| done_o | output | 1 | One-cycle completion pulse |
| misalign_o | output | 1 | Completion was a misaligned access |
| wb_en_o | output | 1 | Register-file write enable |
| wb_rd_o | output | 5 | Destination register index |
| wb_data_o | output | 64 | Register-file write data |

## Verification
A controller stuck in the request state shows up one cycle after the grant, because mem_req_o stays high. One stuck waiting shows up in the cycle after a response, because done_o is missing. A latched operation that is corrupted or overwritten by a start while busy changes mem_addr_o or the strobes during the held request, where it is compared on every cycle. A wrong half-select, wrong extension or wrongly gated write enable shows only in the completion cycle, so every load variant is checked there against data computed from its address.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int XLEN   = 64;
    localparam int ILEN   = 32;
    localparam int REGW   = 5;
    localparam int IMMW   = 12;
    localparam int WORDW  = 32;
    localparam int STRB   = XLEN / 8;
    localparam int WSTRB  = WORDW / 8;

    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;
    localparam logic [2:0] F3_DWORD  = 3'b011;
    localparam logic [2:0] F3_WORDU  = 3'b110;

    typedef enum logic [1:0] {ACC_NONE, ACC_LD, ACC_LWU, ACC_SD} acc_kind_e;
    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} lsu_state_e;

    typedef struct packed {
        acc_kind_e          kind;
        logic [REGW-1:0]    rd;
        logic [XLEN-1:0]    imm;
    } dec_op_t;

    typedef struct packed {
        acc_kind_e          kind;
        logic [REGW-1:0]    rd;
        logic [XLEN-1:0]    addr;
        logic [XLEN-1:0]    wdata;
    } mem_op_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMMW-1:0] v);
        return {{(XLEN-IMMW){v[IMMW-1]}}, v};
    endfunction

    function automatic logic [STRB-1:0] lane_mask(input acc_kind_e k, input logic hi);
        logic [STRB-1:0] m;
        m = {{(STRB-WSTRB){1'b0}}, {WSTRB{1'b1}}};
        if (k == ACC_LWU) begin
            if (hi) m = m << WSTRB;
        end else begin
            m = '1;
        end
        return m;
    endfunction

    function automatic logic [XLEN-1:0] shape_load(input acc_kind_e k, input logic hi,
                                                   input logic [XLEN-1:0] d);
        if (k == ACC_LWU)
            return hi ? {{(XLEN-WORDW){1'b0}}, d[XLEN-1 -: WORDW]}
                      : {{(XLEN-WORDW){1'b0}}, d[WORDW-1:0]};
        return d;
    endfunction

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
    import lsu_pkg::*;
(
    input  logic [ILEN-1:0] instr_i,
    output dec_op_t         dec_o
);
    logic [6:0] opc;
    logic [2:0] f3;
    logic       unused_idx;

    assign opc        = instr_i[6:0];
    assign f3         = instr_i[14:12];
    assign unused_idx = ^instr_i[19:15];

    always_comb begin
        dec_o.kind = ACC_NONE;
        dec_o.rd   = instr_i[11:7];
        dec_o.imm  = sext_imm(instr_i[31:20]);
        if (opc == OPC_LOAD && f3 == F3_DWORD)  dec_o.kind = ACC_LD;
        if (opc == OPC_LOAD && f3 == F3_WORDU)  dec_o.kind = ACC_LWU;
        if (opc == OPC_STORE && f3 == F3_DWORD) begin
            dec_o.kind = ACC_SD;
            dec_o.rd   = '0;
            dec_o.imm  = sext_imm({instr_i[31:25], instr_i[11:7]});
        end
    end
endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_pkg::*;
(
    input  logic [XLEN-1:0] base_i,
    input  dec_op_t         dec_i,
    output logic [XLEN-1:0] addr_o,
    output logic            misalign_o
);
    assign addr_o = base_i + dec_i.imm;

    always_comb begin
        if (dec_i.kind == ACC_LWU) misalign_o = (addr_o[1:0] != 2'b00);
        else                       misalign_o = (addr_o[2:0] != 3'b000);
    end
endmodule

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
    import lsu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  mem_op_t         op_i,
    input  logic            misalign_i,
    output logic            busy_o,
    output logic            mem_req_o,
    input  logic            mem_gnt_i,
    output logic [XLEN-1:0] mem_addr_o,
    output logic            mem_we_o,
    output logic [STRB-1:0] mem_be_o,
    output logic [XLEN-1:0] mem_wdata_o,
    input  logic            mem_rvalid_i,
    input  logic [XLEN-1:0] mem_rdata_i,
    output logic            done_o,
    output logic            misalign_o,
    output logic            wb_en_o,
    output logic [REGW-1:0] wb_rd_o,
    output logic [XLEN-1:0] wb_data_o
);
    lsu_state_e      state_q;
    mem_op_t         op_q;
    logic            done_q, mis_q, wben_q;
    logic [XLEN-1:0] wbdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            op_q     <= '0;
            done_q   <= 1'b0;
            mis_q    <= 1'b0;
            wben_q   <= 1'b0;
            wbdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            mis_q  <= 1'b0;
            wben_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i && op_i.kind != ACC_NONE) begin
                        op_q <= op_i;
                        if (misalign_i) begin
                            done_q   <= 1'b1;
                            mis_q    <= 1'b1;
                            wbdata_q <= '0;
                        end else begin
                            state_q <= ST_REQ;
                        end
                    end
                end
                ST_REQ: begin
                    if (mem_gnt_i) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rvalid_i) begin
                        state_q  <= ST_IDLE;
                        done_q   <= 1'b1;
                        wben_q   <= (op_q.kind != ACC_SD) && (op_q.rd != '0);
                        wbdata_q <= (op_q.kind == ACC_SD) ? '0
                                  : shape_load(op_q.kind, op_q.addr[2], mem_rdata_i);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign mem_req_o   = (state_q == ST_REQ);
    assign mem_addr_o  = op_q.addr;
    assign mem_we_o    = mem_req_o && (op_q.kind == ACC_SD);
    assign mem_be_o    = lane_mask(op_q.kind, op_q.addr[2]);
    assign mem_wdata_o = op_q.wdata;
    assign done_o      = done_q;
    assign misalign_o  = mis_q;
    assign wb_en_o     = wben_q;
    assign wb_rd_o     = op_q.rd;
    assign wb_data_o   = wbdata_q;

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o));
    // R3
    store_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && mem_we_o |-> mem_be_o == '1);
    // R9
    mis_done_chk: assert property (@(posedge clk) disable iff (rst)
        misalign_o |-> done_o && !wb_en_o && !mem_req_o);
    // R9
    aligned_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && mem_be_o == '1 |-> mem_addr_o[2:0] == 3'b000);
    // R7
    rd0_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en_o |-> wb_rd_o != '0);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !mem_req_o && !busy_o);
    // R10
    start_rose_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
    import lsu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [31:0]      instr_i,
    input  logic [63:0]      base_i,
    input  logic [63:0]      src2_i,
    output logic             busy_o,
    output logic             mem_req_o,
    input  logic             mem_gnt_i,
    output logic [63:0]      mem_addr_o,
    output logic             mem_we_o,
    output logic [7:0]       mem_be_o,
    output logic [63:0]      mem_wdata_o,
    input  logic             mem_rvalid_i,
    input  logic [63:0]      mem_rdata_i,
    output logic             done_o,
    output logic             misalign_o,
    output logic             wb_en_o,
    output logic [4:0]       wb_rd_o,
    output logic [63:0]      wb_data_o
);
    dec_op_t         dec;
    logic [XLEN-1:0] ea;
    logic            mis;
    mem_op_t         op;

    lsu_decode u_dec (.instr_i(instr_i), .dec_o(dec));

    lsu_agen u_agen (.base_i(base_i), .dec_i(dec), .addr_o(ea), .misalign_o(mis));

    always_comb begin
        op.kind  = dec.kind;
        op.rd    = dec.rd;
        op.addr  = ea;
        op.wdata = (dec.kind == ACC_SD) ? src2_i : '0;
    end

    lsu_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op), .misalign_i(mis),
        .busy_o(busy_o), .mem_req_o(mem_req_o), .mem_gnt_i(mem_gnt_i),
        .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_be_o(mem_be_o),
        .mem_wdata_o(mem_wdata_o), .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
        .done_o(done_o), .misalign_o(misalign_o), .wb_en_o(wb_en_o),
        .wb_rd_o(wb_rd_o), .wb_data_o(wb_data_o)
    );
endmodule

// File: tb/tb_ldst_unit.sv
module tb_ldst_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [63:0] base_i = '0, src2_i = '0;
    logic        busy_o, mem_req_o, mem_we_o, done_o, misalign_o, wb_en_o;
    logic        mem_gnt_i = 1'b0, mem_rvalid_i = 1'b0;
    logic [63:0] mem_addr_o, mem_wdata_o, wb_data_o;
    logic [63:0] mem_rdata_i = '0;
    logic [7:0]  mem_be_o;
    logic [4:0]  wb_rd_o;
    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    ldst_unit dut (.*);

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_ld(logic [11:0] imm, logic [2:0] f3, logic [4:0] rd);
        return {imm, 5'd1, f3, rd, 7'b0000011};
    endfunction

    function automatic logic [31:0] enc_sd(logic [11:0] imm);
        return {imm[11:5], 5'd2, 5'd1, 3'b011, imm[4:0], 7'b0100011};
    endfunction

    // Issues one operation and plays the memory side; returns observations.
    task automatic run_op(input logic [31:0] ins, input logic [63:0] b, input logic [63:0] s2,
                          input int gdly, input bit poke, input logic [63:0] rdata,
                          output logic [63:0] a, output logic we, output logic [7:0] be,
                          output logic [63:0] wd, output logic dn, output logic wen,
                          output logic [4:0] rd, output logic [63:0] wdat, output logic mis);
        @(negedge clk);
        instr_i = ins; base_i = b; src2_i = s2; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; instr_i = '0; base_i = '0; src2_i = '0;
        chk("R10", "busy after start", busy_o, 1);
        chk("R4", "request raised", mem_req_o, 1);
        a = mem_addr_o; we = mem_we_o; be = mem_be_o; wd = mem_wdata_o;
        for (int i = 0; i < gdly; i++) begin
            if (poke) begin
                start_i = 1'b1; instr_i = enc_ld(12'h000, 3'b011, 5'd9); base_i = 64'h8;
            end
            @(negedge clk);
            start_i = 1'b0; instr_i = '0; base_i = '0;
            chk("R4", "request held", mem_req_o, 1);
            chk("R10", "address stable while busy", mem_addr_o, a);
        end
        mem_gnt_i = 1'b1;
        @(negedge clk);
        mem_gnt_i = 1'b0;
        chk("R4", "request dropped after grant", mem_req_o, 0);
        chk("R8", "no done before response", done_o, 0);
        mem_rvalid_i = 1'b1; mem_rdata_i = rdata;
        @(negedge clk);
        mem_rvalid_i = 1'b0; mem_rdata_i = '0;
        dn = done_o; wen = wb_en_o; rd = wb_rd_o; wdat = wb_data_o; mis = misalign_o;
        @(negedge clk);
        chk("R8", "done is one cycle", done_o, 0);
        chk("R10", "idle after completion", busy_o, 0);
    endtask

    logic [63:0] a, wd, wdat;
    logic        we, dn, wen, mis;
    logic [7:0]  be;
    logic [4:0]  rd;

    task automatic t_reset();
        chk("R10", "reset busy", busy_o, 0);
        chk("R4", "reset req", mem_req_o, 0);
        chk("R8", "reset done", done_o, 0);
        chk("R7", "reset wb_en", wb_en_o, 0);
    endtask

    task automatic t_ld();
        run_op(enc_ld(12'hFF8, 3'b011, 5'd5), 64'h1000, 64'h0, 0, 0,
               64'h8877665544332211, a, we, be, wd, dn, wen, rd, wdat, mis);
        chk("R2", "LD address", a, 64'h0FF8);
        chk("R1", "LD read", we, 0);
        chk("R6", "LD strobes", be, 8'hFF);
        chk("R8", "LD done", dn, 1);
        chk("R5", "LD wb_en", wen, 1);
        chk("R5", "LD rd", rd, 5);
        chk("R5", "LD data", wdat, 64'h8877665544332211);
        chk("R9", "LD no misalign", mis, 0);
    endtask

    task automatic t_lwu(input logic [11:0] imm, input logic [63:0] exp_a,
                         input logic [7:0] exp_be, input logic [63:0] exp_d);
        run_op(enc_ld(imm, 3'b110, 5'd7), 64'h2000, 64'h0, 1, 0,
               64'hDEADBEEF80000001, a, we, be, wd, dn, wen, rd, wdat, mis);
        chk("R2", "LWU address", a, exp_a);
        chk("R6", "LWU strobes", be, exp_be);
        chk("R6", "LWU wb_en", wen, 1);
        chk("R6", "LWU data", wdat, exp_d);
    endtask

    task automatic t_sd();
        run_op(enc_sd(12'hFF0), 64'h3000, 64'hA5A5_0123_4567_89AB, 2, 0,
               64'h0, a, we, be, wd, dn, wen, rd, wdat, mis);
        chk("R3", "SD address", a, 64'h2FF0);
        chk("R3", "SD write enable", we, 1);
        chk("R3", "SD strobes", be, 8'hFF);
        chk("R3", "SD data", wd, 64'hA5A5_0123_4567_89AB);
        chk("R8", "SD done", dn, 1);
        chk("R8", "SD no writeback", wen, 0);
    endtask

    task automatic t_rd0();
        run_op(enc_ld(12'h010, 3'b011, 5'd0), 64'h4000, 64'h0, 0, 0,
               64'h1234, a, we, be, wd, dn, wen, rd, wdat, mis);
        chk("R7", "rd0 access address", a, 64'h4010);
        chk("R7", "rd0 done", dn, 1);
        chk("R7", "rd0 no write", wen, 0);
    endtask

    task automatic t_hold();
        run_op(enc_ld(12'h020, 3'b011, 5'd3), 64'h5000, 64'h0, 3, 1,
               64'hCAFE, a, we, be, wd, dn, wen, rd, wdat, mis);
        chk("R10", "held op address", a, 64'h5020);
        chk("R10", "held op rd", rd, 3);
        chk("R4", "held op data", wdat, 64'hCAFE);
    endtask

    task automatic t_mis(input logic [31:0] ins, input logic [63:0] b, input string tag);
        @(negedge clk);
        instr_i = ins; base_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; instr_i = '0; base_i = '0;
        chk("R9", {tag, " done"}, done_o, 1);
        chk("R9", {tag, " flag"}, misalign_o, 1);
        chk("R9", {tag, " no request"}, mem_req_o, 0);
        chk("R9", {tag, " no write"}, wb_en_o, 0);
        @(negedge clk);
        chk("R9", {tag, " flag clears"}, misalign_o, 0);
    endtask

    task automatic t_illegal();
        @(negedge clk);
        instr_i = 32'h0020_81B3; base_i = 64'h100; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; instr_i = '0;
        chk("R1", "other opcode busy", busy_o, 0);
        chk("R1", "other opcode req", mem_req_o, 0);
        chk("R1", "other opcode done", done_o, 0);
        @(negedge clk);
        instr_i = {12'h0, 5'd1, 3'b010, 5'd4, 7'b0000011}; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; instr_i = '0;
        chk("R1", "other funct3 req", mem_req_o, 0);
        chk("R1", "other funct3 done", done_o, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ld();
        t_lwu(12'h010, 64'h2010, 8'h0F, 64'h0000000080000001);
        t_lwu(12'h014, 64'h2014, 8'hF0, 64'h00000000DEADBEEF);
        t_sd();
        t_rd0();
        t_hold();
        t_mis(enc_ld(12'h004, 3'b011, 5'd2), 64'h1000, "LD");
        t_mis(enc_ld(12'h002, 3'b110, 5'd2), 64'h1000, "LWU");
        t_mis(enc_sd(12'h001), 64'h1000, "SD");
        t_illegal();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule